// File: doc/BRIEF.md
# Widening Lane Arithmetic Unit

This block carries out the "long" family of vector lane operations on one 64-bit half-vector per cycle. A size code picks the narrow source lane width: 8, 16 or 32 bits. The selected half of each 128-bit source is split into lanes of that width. Each lane is widened to twice its width before the arithmetic, so every result fills a lane of the 128-bit output with no loss. One group of operations also reads a 128-bit accumulator vector of double-width lanes and folds the new value into it.

The operations are:

- widening add and widening subtract;
- absolute difference, alone or accumulated;
- multiply, alone or accumulated;
- signed doubling multiply with saturation, alone, accumulated or subtracted.

The saturating accumulate forms clip twice. The doubled product is saturated first. The accumulate is then a saturating add, and the subtract form negates the doubled product before that add.

A request is registered and answered on the next clock edge. Encodings the unit does not accept are flagged as illegal. A sticky flag records that some lane clipped, and it holds until it is cleared.

Top module: `widen_lane_unit`

## Requirements
- R1: `res_valid_o` is `op_valid_i` delayed by one clock. `result_o` and `illegal_o` describe the request of the previous cycle. A cycle with no request gives `result_o` = 0 and `illegal_o` = 0.
- R2: When `upper_half_i` = 1, the narrow lanes come from bits [127:64] of both sources. When it is 0, they come from bits [63:0].
- R3: Size code 0, 1 and 2 select narrow lanes of 8, 16 and 32 bits. Narrow lane i sits at bits [NW*i +: NW] of the selected half. Result lane i and accumulator lane i sit at [2NW*i +: 2NW].
- R4: Opcode 0 adds and opcode 2 subtracts (a minus b). Both operands are zero-extended when `is_unsigned_i` = 1 and sign-extended otherwise. The result wraps modulo the result lane width and never saturates.
- R5: Opcode 7 gives |a − b| and opcode 12 gives a × b. Both are computed on the extended operands and are exact in the double-width lane.
- R6: Opcode 5 adds |a − b| to the accumulator lane. Opcode 8 adds a × b to the accumulator lane. Both wrap modulo the lane width.
- R7: Opcode 13 gives 2 × a × b on signed operands, clamped to the signed range of the result lane. The only case that clips is most-negative times most-negative, which yields the most positive value.
- R8: Opcode 9 adds the saturated doubled product to the accumulator lane. Opcode 11 subtracts it. In both, the final sum is clamped to the signed range of the lane.
- R9: A request is illegal in any of these cases: size code 3; an opcode outside {0,2,5,7,8,9,11,12,13}, which includes every opcode 14; or opcode 9, 11 or 13 with `is_unsigned_i` = 1 or size code 0. An illegal request gives `result_o` = 0, raises `illegal_o`, and never sets the sticky flag.
- R10: `sat_sticky_o` becomes 1 after a legal request in which any lane clipped, in the doubling step or in the accumulate step. It stays 1 until a cycle with `sat_clear_i` = 1 and no new clip. A clip in the same cycle as a clear keeps the flag at 1.
- R11: After a synchronous reset, `res_valid_o`, `result_o`, `illegal_o` and `sat_sticky_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Request strobe |
| opcode_i | input | 4 | Operation code |
| size_i | input | 2 | Narrow lane size code |
| is_unsigned_i | input | 1 | Zero-extend operands when 1 |
| upper_half_i | input | 1 | Take lanes from the upper source half |
| src_a_i | input | 128 | First source vector |
| src_b_i | input | 128 | Second source vector |
| acc_i | input | 128 | Accumulator vector |
| sat_clear_i | input | 1 | Clears the sticky saturation flag |
| res_valid_o | output | 1 | Result strobe |
| result_o | output | 128 | Double-width result vector |
| illegal_o | output | 1 | Previous request was an illegal encoding |
| sat_sticky_o | output | 1 | Sticky saturation flag |

## Verification
The bench drives every combination of opcode, size code, signedness and half select, and compares each result with a behavioural lane model.

It targets most-negative times most-negative for the doubling operations at 16-bit and 32-bit sizes. A unit that skipped the doubling clamp would return the most negative value there and leave the sticky flag clear. It also pushes the saturating accumulate to both rails. A unit that wrapped the sum, or subtracted without negating first, would return a value of the wrong sign.

It runs a clip and a clear in the same cycle. It also checks that illegal encodings, including unsigned or 8-bit doubling requests, neither produce data nor disturb the sticky flag.

// File: rtl/wl_pkg.sv
package wl_pkg;

    localparam int HALF_W    = 64;
    localparam int VEC_W     = 2 * HALF_W;
    localparam int BASE_NW   = 8;
    localparam int NUM_SIZES = 3;

    localparam logic [3:0] OPC_ADDL   = 4'd0;
    localparam logic [3:0] OPC_SUBL   = 4'd2;
    localparam logic [3:0] OPC_ABAL   = 4'd5;
    localparam logic [3:0] OPC_ABDL   = 4'd7;
    localparam logic [3:0] OPC_MLAL   = 4'd8;
    localparam logic [3:0] OPC_QDMLAL = 4'd9;
    localparam logic [3:0] OPC_QDMLSL = 4'd11;
    localparam logic [3:0] OPC_MULL   = 4'd12;
    localparam logic [3:0] OPC_QDMULL = 4'd13;

    typedef enum logic [2:0] {
        K_ADD,
        K_SUB,
        K_ABD,
        K_MUL,
        K_QDMUL
    } kind_e;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_ADD,
        ACC_SUB
    } acc_e;

    typedef struct packed {
        logic  legal;
        kind_e kind;
        acc_e  acc;
    } lane_ctl_t;

endpackage

// File: rtl/wl_decode.sv
module wl_decode
    import wl_pkg::*;
(
    input  logic [3:0] opcode_i,
    input  logic [1:0] size_i,
    input  logic       uns_i,
    output lane_ctl_t  ctl_o
);

    logic qd_ok;

    always_comb begin
        // Doubling forms accept only signed operands of 16 or 32 bits.
        qd_ok       = !uns_i && (size_i != 2'd0);
        ctl_o.legal = 1'b1;
        ctl_o.kind  = K_ADD;
        ctl_o.acc   = ACC_NONE;
        unique case (opcode_i)
            OPC_ADDL:   ctl_o.kind = K_ADD;
            OPC_SUBL:   ctl_o.kind = K_SUB;
            OPC_ABDL:   ctl_o.kind = K_ABD;
            OPC_ABAL: begin
                ctl_o.kind = K_ABD;
                ctl_o.acc  = ACC_ADD;
            end
            OPC_MULL:   ctl_o.kind = K_MUL;
            OPC_MLAL: begin
                ctl_o.kind = K_MUL;
                ctl_o.acc  = ACC_ADD;
            end
            OPC_QDMULL: begin
                ctl_o.kind  = K_QDMUL;
                ctl_o.legal = qd_ok;
            end
            OPC_QDMLAL: begin
                ctl_o.kind  = K_QDMUL;
                ctl_o.acc   = ACC_ADD;
                ctl_o.legal = qd_ok;
            end
            OPC_QDMLSL: begin
                ctl_o.kind  = K_QDMUL;
                ctl_o.acc   = ACC_SUB;
                ctl_o.legal = qd_ok;
            end
            default:    ctl_o.legal = 1'b0;
        endcase
        if (size_i == 2'd3) begin
            ctl_o.legal = 1'b0;
        end
    end

endmodule

// File: rtl/wl_lane.sv
module wl_lane
    import wl_pkg::*;
#(
    parameter int NW = 8
) (
    input  logic [NW-1:0]   a_i,
    input  logic [NW-1:0]   b_i,
    input  logic [2*NW-1:0] acc_i,
    input  lane_ctl_t       ctl_i,
    input  logic            uns_i,
    output logic [2*NW-1:0] res_o,
    output logic            clip_o
);

    localparam int DW = 2 * NW;
    localparam int EW = DW + 2;
    localparam logic signed [EW-1:0] SAT_HI = {3'b000, {(DW-1){1'b1}}};
    localparam logic signed [EW-1:0] SAT_LO = {3'b111, {(DW-1){1'b0}}};

    function automatic logic signed [EW-1:0] clamp(input logic signed [EW-1:0] v);
        if (v > SAT_HI) return SAT_HI;
        if (v < SAT_LO) return SAT_LO;
        return v;
    endfunction

    logic signed [EW-1:0] ea, eb, eacc;
    logic signed [EW-1:0] diff, mag, prod;
    logic signed [EW-1:0] dbl, dsat, qaddend, qsum, qsat;
    logic signed [EW-1:0] core;
    logic signed [EW-1:0] full;

    always_comb begin
        ea   = {{(EW-NW){a_i[NW-1] & ~uns_i}}, a_i};
        eb   = {{(EW-NW){b_i[NW-1] & ~uns_i}}, b_i};
        eacc = {{2{acc_i[DW-1]}}, acc_i};

        diff = ea - eb;
        mag  = diff[EW-1] ? -diff : diff;
        prod = ea * eb;

        // Doubling step, then the optional saturating accumulate.
        dbl     = prod + prod;
        dsat    = clamp(dbl);
        qaddend = (ctl_i.acc == ACC_SUB) ? -dsat : dsat;
        qsum    = eacc + qaddend;
        qsat    = clamp(qsum);

        unique case (ctl_i.kind)
            K_ADD:   core = ea + eb;
            K_SUB:   core = diff;
            K_ABD:   core = mag;
            K_MUL:   core = prod;
            default: core = dsat;
        endcase

        if (ctl_i.kind == K_QDMUL) begin
            full   = (ctl_i.acc == ACC_NONE) ? dsat : qsat;
            clip_o = (dsat != dbl) || ((ctl_i.acc != ACC_NONE) && (qsat != qsum));
        end else begin
            unique case (ctl_i.acc)
                ACC_ADD: full = eacc + core;
                ACC_SUB: full = eacc - core;
                default: full = core;
            endcase
            clip_o = 1'b0;
        end
        res_o = full[DW-1:0];
    end

endmodule

// File: rtl/wl_lane_array.sv
module wl_lane_array
    import wl_pkg::*;
#(
    parameter int NW = 8,
    parameter int HW = 64
) (
    input  logic [HW-1:0]   a_i,
    input  logic [HW-1:0]   b_i,
    input  logic [2*HW-1:0] acc_i,
    input  lane_ctl_t       ctl_i,
    input  logic            uns_i,
    output logic [2*HW-1:0] res_o,
    output logic            clip_o
);

    localparam int LANES = HW / NW;
    localparam int DW    = 2 * NW;

    logic [LANES-1:0] clip_v;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        wl_lane #(.NW(NW)) u_lane (
            .a_i    (a_i[l*NW +: NW]),
            .b_i    (b_i[l*NW +: NW]),
            .acc_i  (acc_i[l*DW +: DW]),
            .ctl_i  (ctl_i),
            .uns_i  (uns_i),
            .res_o  (res_o[l*DW +: DW]),
            .clip_o (clip_v[l])
        );
    end

    assign clip_o = |clip_v;

endmodule

// File: rtl/widen_lane_unit.sv
module widen_lane_unit
    import wl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid_i,
    input  logic [3:0]       opcode_i,
    input  logic [1:0]       size_i,
    input  logic             is_unsigned_i,
    input  logic             upper_half_i,
    input  logic [127:0]     src_a_i,
    input  logic [127:0]     src_b_i,
    input  logic [127:0]     acc_i,
    input  logic             sat_clear_i,
    output logic             res_valid_o,
    output logic [127:0]     result_o,
    output logic             illegal_o,
    output logic             sat_sticky_o
);

    lane_ctl_t           ctl;
    logic [HALF_W-1:0]   half_a, half_b;
    logic [VEC_W-1:0]    res_by_size  [NUM_SIZES];
    logic                clip_by_size [NUM_SIZES];
    logic [VEC_W-1:0]    res_sel;
    logic                clip_sel;

    wl_decode u_dec (
        .opcode_i (opcode_i),
        .size_i   (size_i),
        .uns_i    (is_unsigned_i),
        .ctl_o    (ctl)
    );

    assign half_a = upper_half_i ? src_a_i[VEC_W-1:HALF_W] : src_a_i[HALF_W-1:0];
    assign half_b = upper_half_i ? src_b_i[VEC_W-1:HALF_W] : src_b_i[HALF_W-1:0];

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        localparam int NW = BASE_NW << s;
        wl_lane_array #(.NW(NW), .HW(HALF_W)) u_arr (
            .a_i    (half_a),
            .b_i    (half_b),
            .acc_i  (acc_i),
            .ctl_i  (ctl),
            .uns_i  (is_unsigned_i),
            .res_o  (res_by_size[s]),
            .clip_o (clip_by_size[s])
        );
    end

    always_comb begin
        res_sel  = '0;
        clip_sel = 1'b0;
        for (int s = 0; s < NUM_SIZES; s++) begin
            if (int'(size_i) == s) begin
                res_sel  = res_by_size[s];
                clip_sel = clip_by_size[s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid_o  <= 1'b0;
            result_o     <= '0;
            illegal_o    <= 1'b0;
            sat_sticky_o <= 1'b0;
        end else begin
            res_valid_o <= op_valid_i;
            result_o    <= (op_valid_i && ctl.legal) ? res_sel : '0;
            illegal_o   <= op_valid_i && !ctl.legal;
            if (op_valid_i && ctl.legal && clip_sel) begin
                sat_sticky_o <= 1'b1;
            end else if (sat_clear_i) begin
                sat_sticky_o <= 1'b0;
            end
        end
    end

    AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
        op_valid_i |=> res_valid_o) else $error("valid pipe");                 // R1
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (result_o == '0)) else $error("illegal data");           // R9
    AST_QD_UNSIGNED_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && (opcode_i == OPC_QDMULL) && is_unsigned_i) |=> illegal_o)
        else $error("unsigned doubling accepted");                             // R9
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sat_sticky_o && !sat_clear_i) |=> sat_sticky_o) else $error("sticky lost"); // R10
    AST_STICKY_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(sat_sticky_o) |-> $past(op_valid_i && ctl.legal && (ctl.kind == K_QDMUL)))
        else $error("sticky from non-saturating op");                          // R10

endmodule

// File: tb/sim_widen_lane_unit.sv
`timescale 1ns/1ps
module sim_widen_lane_unit;

    logic         clk = 1'b0;
    logic         rst;
    logic         op_valid;
    logic [3:0]   opcode;
    logic [1:0]   size;
    logic         uns;
    logic         upper;
    logic [127:0] src_a, src_b, acc;
    logic         clr;
    logic         res_valid;
    logic [127:0] result;
    logic         illegal;
    logic         sticky;

    always #4 clk = ~clk;

    widen_lane_unit u0 (
        .clk (clk), .rst (rst), .op_valid_i (op_valid), .opcode_i (opcode),
        .size_i (size), .is_unsigned_i (uns), .upper_half_i (upper),
        .src_a_i (src_a), .src_b_i (src_b), .acc_i (acc), .sat_clear_i (clr),
        .res_valid_o (res_valid), .result_o (result), .illegal_o (illegal),
        .sat_sticky_o (sticky)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;

    // expectations for the cycle after the current request
    bit           exp_valid, exp_ill, exp_sticky;
    logic [127:0] exp_res;
    string        exp_tag;
    bit           model_sticky;

    function automatic logic signed [129:0] sx(input logic [127:0] v, input int w, input bit u);
        logic signed [129:0] r;
        r = '0;
        r[127:0] = v;
        r = r & ((130'sd1 <<< w) - 1);
        if (!u && r[w-1]) r = r - (130'sd1 <<< w);
        return r;
    endfunction

    function automatic logic signed [129:0] rsat(input logic signed [129:0] v, input int dw, inout bit s);
        logic signed [129:0] hi, lo;
        hi = (130'sd1 <<< (dw-1)) - 1;
        lo = -(130'sd1 <<< (dw-1));
        if (v > hi) begin s = 1; return hi; end
        if (v < lo) begin s = 1; return lo; end
        return v;
    endfunction

    function automatic bit ref_legal(input int op, input int sz, input bit u);
        if (sz == 3) return 0;
        case (op)
            0, 2, 5, 7, 8, 12: return 1;
            9, 11, 13:         return !u && sz != 0;
            default:           return 0;
        endcase
    endfunction

    function automatic logic [127:0] ref_vec(input int op, input int sz, input bit u, input bit hi,
                                             input logic [127:0] a, input logic [127:0] b,
                                             input logic [127:0] c, inout bit s);
        int nw, dw;
        logic [127:0] ha, hb, outv;
        logic signed [129:0] x, y, z, v, d;
        nw = 8 << sz;
        dw = 2 * nw;
        ha = hi ? (a >> 64) : {64'd0, a[63:0]};
        hb = hi ? (b >> 64) : {64'd0, b[63:0]};
        outv = '0;
        for (int i = 0; i < 64 / nw; i++) begin
            x = sx(ha >> (i*nw), nw, u);
            y = sx(hb >> (i*nw), nw, u);
            z = sx(c >> (i*dw), dw, 0);
            d = (x > y) ? x - y : y - x;
            case (op)
                0:  v = x + y;
                2:  v = x - y;
                7:  v = d;
                5:  v = z + d;
                12: v = x * y;
                8:  v = z + x * y;
                13: v = rsat(2 * x * y, dw, s);
                9:  v = rsat(z + rsat(2 * x * y, dw, s), dw, s);
                default: v = rsat(z - rsat(2 * x * y, dw, s), dw, s);
            endcase
            v = v & ((130'sd1 <<< dw) - 1);
            outv = outv | (v[127:0] << (i*dw));
        end
        return outv;
    endfunction

    function automatic string tag_of(input int op, input bit legal);
        if (!legal) return "R9";
        case (op)
            0, 2:    return "R4";
            7, 12:   return "R5";
            5, 8:    return "R6";
            13:      return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk1(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_prev();
        chk1("R1", "res_valid", {127'd0, res_valid}, {127'd0, exp_valid});
        chk1(exp_valid ? "R9" : "R1", "illegal", {127'd0, illegal}, {127'd0, exp_ill});
        chk1("R10", "sticky", {127'd0, sticky}, {127'd0, exp_sticky});
        chk1(exp_valid ? exp_tag : "R1", "result", result, exp_res);
    endtask

    // Checks the previous cycle at the falling edge, then drives the next request.
    task automatic issue(input bit v, input int op, input int sz, input bit u, input bit hi,
                         input logic [127:0] a, input logic [127:0] b, input logic [127:0] c,
                         input bit cl, input string tag);
        bit lg, s;
        @(negedge clk);
        check_prev();
        op_valid = v; opcode = op[3:0]; size = sz[1:0]; uns = u; upper = hi;
        src_a = a; src_b = b; acc = c; clr = cl;
        lg = ref_legal(op, sz, u);
        s = 0;
        exp_valid = v;
        exp_ill   = v && !lg;
        exp_res   = (v && lg) ? ref_vec(op, sz, u, hi, a, b, c, s) : '0;
        if (v && lg && s) model_sticky = 1;
        else if (cl) model_sticky = 0;
        exp_sticky = model_sticky;
        exp_tag = (tag != "") ? tag : tag_of(op, lg);
    endtask

    function automatic logic [63:0] min_pat(input int sz);
        case (sz)
            0:       return {8{8'h80}};
            1:       return {4{16'h8000}};
            default: return {2{32'h8000_0000}};
        endcase
    endfunction

    function automatic logic [63:0] max_pat(input int sz);
        case (sz)
            0:       return {8{8'h7f}};
            1:       return {4{16'h7fff}};
            default: return {2{32'h7fff_ffff}};
        endcase
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; op_valid = 0; opcode = 0; size = 0; uns = 0; upper = 0;
        src_a = '0; src_b = '0; acc = '0; clr = 0;
        model_sticky = 0;
        exp_valid = 0; exp_ill = 0; exp_sticky = 0; exp_res = '0; exp_tag = "R11";
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk1("R11", "res_valid", {127'd0, res_valid}, 128'd0);
        chk1("R11", "result", result, 128'd0);
        chk1("R11", "illegal", {127'd0, illegal}, 128'd0);
        chk1("R11", "sticky", {127'd0, sticky}, 128'd0);
        rst = 0;

        // R2: upper half select, lower half holds different data
        issue(1, 0, 0, 1, 1, {64'h0102030405060708, 64'hffffffffffffffff},
              {64'h1010101010101010, 64'h0}, '0, 0, "R2");
        issue(1, 0, 0, 1, 0, {64'h0102030405060708, 64'hffffffffffffffff},
              {64'h1010101010101010, 64'h0}, '0, 0, "R2");
        // R3: distinct 32-bit lanes in multiply
        issue(1, 12, 2, 1, 0, {64'd0, 32'd7, 32'd3}, {64'd0, 32'd5, 32'd11}, '0, 0, "R3");
        issue(1, 0, 1, 0, 0, {64'd0, 16'h8000, 16'h0001, 16'h7fff, 16'hffff},
              {64'd0, 16'h8000, 16'h0002, 16'h7fff, 16'h0001}, '0, 0, "R3");

        // every opcode, size, signedness and half
        for (int op = 0; op < 16; op++)
            for (int sz = 0; sz < 4; sz++)
                for (int u = 0; u < 2; u++)
                    for (int h = 0; h < 2; h++)
                        issue(1, op, sz, u[0], h[0], rnd128(), rnd128(), rnd128(), 1, "");

        // R7: most negative squared clips to max, sets sticky
        for (int sz = 1; sz < 3; sz++) begin
            issue(1, 13, sz, 0, 0, {64'd0, min_pat(sz)}, {64'd0, min_pat(sz)}, '0, 0, "R7");
            issue(0, 0, 0, 0, 0, '0, '0, '0, 1, "R10");
            // R8: accumulate to positive rail, then subtract to negative rail
            issue(1, 9, sz, 0, 0, {64'd0, max_pat(sz)}, {64'd0, max_pat(sz)},
                  (sz == 1) ? {4{32'h7fff_0000}} : {2{64'h7fff_ffff_0000_0000}}, 0, "R8");
            issue(1, 11, sz, 0, 1, {max_pat(sz), 64'd0}, {max_pat(sz), 64'd0},
                  (sz == 1) ? {4{32'h8000_0100}} : {2{64'h8000_0000_0000_0100}}, 1, "R8");
            // R8: doubling clips, accumulate of -1 does not
            issue(1, 9, sz, 0, 0, {64'd0, min_pat(sz)}, {64'd0, min_pat(sz)}, {128{1'b1}}, 1, "R8");
            issue(1, 11, sz, 0, 0, {64'd0, min_pat(sz)}, {64'd0, min_pat(sz)}, '0, 1, "R8");
        end
        // R10: clip and clear together keep the flag set; then idle hold; then clear
        issue(1, 13, 1, 0, 0, {64'd0, min_pat(1)}, {64'd0, min_pat(1)}, '0, 1, "R10");
        issue(0, 0, 0, 0, 0, '0, '0, '0, 0, "R10");
        // R9: illegal doubling requests do not touch the sticky flag
        issue(1, 13, 0, 0, 0, {64'd0, min_pat(0)}, {64'd0, min_pat(0)}, '0, 0, "R9");
        issue(1, 13, 1, 1, 0, {64'd0, min_pat(1)}, {64'd0, min_pat(1)}, '0, 0, "R9");
        issue(1, 14, 0, 0, 0, rnd128(), rnd128(), '0, 0, "R9");
        issue(0, 0, 0, 0, 0, '0, '0, '0, 1, "R10");
        issue(1, 13, 0, 0, 0, {64'd0, min_pat(0)}, {64'd0, min_pat(0)}, '0, 0, "R9");

        // random traffic with corner operands
        for (int k = 0; k < 3000; k++) begin
            int op, sz, pick;
            logic [127:0] a, b;
            pick = $urandom_range(0, 8);
            op = (pick == 0) ? 0 : (pick == 1) ? 2 : (pick == 2) ? 5 : (pick == 3) ? 7 :
                 (pick == 4) ? 8 : (pick == 5) ? 9 : (pick == 6) ? 11 : (pick == 7) ? 12 : 13;
            sz = $urandom_range(0, 2);
            a = rnd128();
            b = rnd128();
            if ($urandom_range(0, 7) == 0) begin
                a = {min_pat(sz), min_pat(sz)};
                b = {min_pat(sz), min_pat(sz)};
            end
            issue($urandom_range(0, 3) != 0, op, sz, $urandom_range(0, 3) == 0, $urandom_range(0, 1),
                  a, b, rnd128(), $urandom_range(0, 15) == 0, "");
        end
        issue(0, 0, 0, 0, 0, '0, '0, '0, 0, "");
        @(negedge clk);
        check_prev();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule